// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block orders the bulk copies between a volatile SRAM array and its nonvolatile shadow. A store first wipes the shadow and then programs every shadow cell from the SRAM at once. A recall first zeroes the SRAM and then loads it from the shadow. Each phase lasts a set number of clock cycles, and every duration is a parameter. While a phase runs, the block raises `busy` to shut the external port. Through `done` it reports each copy that finishes.

A store can start in two ways. Software can ask for one, or the supply comparator (`vcc_ok`) can fall. The supply-driven store runs only if an accepted SRAM write has happened since the last copy. Software stores are refused at low supply, and a software store that is running stops when the supply falls. Recalls are never cut short. After reset a power-up recall waits until the supply comes up. A software recall asked for at low supply is held and starts at that same rise, and the recall then lasts the restore period.

States: `ST_LOWPWR` (supply low, port shut), `ST_IDLE` (port open), `ST_ERASE` and `ST_PROG` (store), `ST_CLEAR` and `ST_LOAD` (recall). Transitions:
- **supply-up**: `ST_LOWPWR` to `ST_CLEAR` when a recall is pending, otherwise to `ST_IDLE`.
- **supply-down**: `ST_IDLE` to `ST_ERASE` when the written flag is set, otherwise to `ST_LOWPWR`.
- **soft-store**: `ST_IDLE` to `ST_ERASE`.
- **soft-recall**: `ST_IDLE` to `ST_CLEAR`.
- **phase-end**: `ST_ERASE` to `ST_PROG`, and `ST_CLEAR` to `ST_LOAD`.
- **finish**: `ST_PROG` or `ST_LOAD` back to `ST_IDLE`, or to `ST_LOWPWR` when the supply is low.
- **abort**: a software store in `ST_ERASE` or `ST_PROG` goes to `ST_LOWPWR`.

Top module: `nv_xfer_ctrl`

## Requirements
- R1: While reset is applied and after it is released with `vcc_ok` low, `busy` is 1 and `erase_cmd`, `prog_cmd`, `clear_cmd`, `xfer_cmd` and `done` are 0. A power-up recall is pending and the written flag is clear.
- R2: When `vcc_ok` rises with a recall pending, a recall starts on the next edge. It runs with `clear_cmd` for CLEAR_CYC cycles and then `xfer_cmd` for RESTORE_CYC-CLEAR_CYC cycles. When `vcc_ok` rises with no recall pending, the block goes idle (`busy` 0) and does not recall.
- R3: A store drives `erase_cmd` for ERASE_CYC cycles and then `prog_cmd` for PROG_CYC cycles. Erase always comes before program.
- R4: A software recall drives `clear_cmd` for CLEAR_CYC cycles and then `xfer_cmd` for RECALL_CYC-CLEAR_CYC cycles. It never drives `erase_cmd` or `prog_cmd`, so the shadow is left untouched.
- R5: When `vcc_ok` is low while idle, a store starts if the written flag is set. If the flag is clear, the block enters low power with no store.
- R6: The written flag is set by an accepted write. A write is accepted when `sram_wr` is 1 while idle with `vcc_ok` high and no request is present. The flag is cleared when any store or recall completes.
- R7: `sw_store_req` while idle with `vcc_ok` high starts a store whether or not the written flag is set.
- R8: `busy` is 1 in every state except idle. `sram_wr` and both request inputs have no effect while a copy is running.
- R9: In low power, `sw_store_req` is ignored. `sw_recall_req` is held and starts a recall when `vcc_ok` rises.
- R10: A software store that sees `vcc_ok` low stops on the next edge. No `done` is raised and the block enters low power. Supply-driven stores and recalls always run to the end.
- R11: When `sw_store_req` and `sw_recall_req` are both 1 in the same idle cycle, the store runs and the recall is discarded.
- R12: `done` is a one-cycle pulse in the last cycle of each completed store or recall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| vcc_ok | input | 1 | Supply comparator: 1 when the supply is above the switch threshold |
| sw_store_req | input | 1 | Software store request |
| sw_recall_req | input | 1 | Software recall request |
| sram_wr | input | 1 | SRAM write strobe from the port |
| erase_cmd | output | 1 | Erase the nonvolatile shadow |
| prog_cmd | output | 1 | Program the shadow from the SRAM |
| clear_cmd | output | 1 | Zero the SRAM array |
| xfer_cmd | output | 1 | Copy the shadow into the SRAM |
| busy | output | 1 | Port disabled |
| done | output | 1 | Copy completed (one-cycle pulse) |

## Verification
Two pairs of events can land in the same idle cycle: a store request with a recall request, and a write strobe with a request. The bench raises both requests in the same cycle and requires a full erase and program, no clear cycle, and the freshly written byte in the shadow model. The abort case makes a running software store meet a falling supply. The bench drops `vcc_ok` one cycle into the erase phase. It then expects an erase shorter than ERASE_CYC, no program cycle, no `done`, and `busy` still high.

// File: rtl/nv_xfer_pkg.sv
package nv_xfer_pkg;

    typedef enum logic [2:0] {
        ST_LOWPWR = 3'd0,
        ST_IDLE   = 3'd1,
        ST_ERASE  = 3'd2,
        ST_PROG   = 3'd3,
        ST_CLEAR  = 3'd4,
        ST_LOAD   = 3'd5
    } nv_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nv_phase_timer.sv
module nv_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);

    // R3/R4: phase lengths rely on a steady one-per-cycle countdown
    a_r3_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    a_r3_timer_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/nv_flag_keeper.sv
module nv_flag_keeper (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_accept,
    input  logic xfer_done,
    input  logic recall_latch,
    input  logic recall_start,
    output logic written,
    output logic recall_pend
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            written     <= 1'b0;
            recall_pend <= 1'b1;
        end else begin
            if (xfer_done)
                written <= 1'b0;
            else if (wr_accept)
                written <= 1'b1;

            if (recall_start)
                recall_pend <= 1'b0;
            else if (recall_latch)
                recall_pend <= 1'b1;
        end
    end

    // R6: completion wipes the written flag
    a_r6_written_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !written);

    // R9: a held recall survives until it is started
    a_r9_pend_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (recall_pend && !recall_start) |=> recall_pend);

endmodule

// File: rtl/nv_xfer_ctrl.sv
module nv_xfer_ctrl
    import nv_xfer_pkg::*;
#(
    parameter int unsigned ERASE_CYC   = 625000,
    parameter int unsigned PROG_CYC    = 625000,
    parameter int unsigned CLEAR_CYC   = 250,
    parameter int unsigned RECALL_CYC  = 2500,
    parameter int unsigned RESTORE_CYC = 81250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_ok,
    input  logic sw_store_req,
    input  logic sw_recall_req,
    input  logic sram_wr,
    output logic erase_cmd,
    output logic prog_cmd,
    output logic clear_cmd,
    output logic xfer_cmd,
    output logic busy,
    output logic done
);
    localparam int unsigned MAX_CYC =
        max2(max2(ERASE_CYC, PROG_CYC), max2(max2(CLEAR_CYC, RECALL_CYC), RESTORE_CYC));
    localparam int CNT_W = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] ERASE_V   = CNT_W'(ERASE_CYC - 1);
    localparam logic [CNT_W-1:0] PROG_V    = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0] CLEAR_V   = CNT_W'(CLEAR_CYC - 1);
    localparam logic [CNT_W-1:0] SW_LOAD_V = CNT_W'(RECALL_CYC - CLEAR_CYC - 1);
    localparam logic [CNT_W-1:0] PU_LOAD_V = CNT_W'(RESTORE_CYC - CLEAR_CYC - 1);

    nv_state_e        state_q, state_d;
    logic             soft_q, soft_d;
    logic             tmr_load, tmr_last;
    logic [CNT_W-1:0] tmr_val;
    logic             wr_accept, xfer_done, rec_latch, rec_start;
    logic             written, recall_pend;

    nv_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    nv_flag_keeper u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_accept    (wr_accept),
        .xfer_done    (xfer_done),
        .recall_latch (rec_latch),
        .recall_start (rec_start),
        .written      (written),
        .recall_pend  (recall_pend)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOWPWR;
            soft_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            soft_q  <= soft_d;
        end
    end

    // next state and phase timing
    always_comb begin
        state_d   = state_q;
        soft_d    = soft_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        wr_accept = 1'b0;
        xfer_done = 1'b0;
        rec_latch = 1'b0;
        rec_start = 1'b0;
        unique case (state_q)
            ST_LOWPWR: begin
                rec_latch = sw_recall_req;
                if (vcc_ok) begin
                    if (recall_pend || sw_recall_req) begin
                        state_d   = ST_CLEAR;
                        soft_d    = 1'b0;
                        tmr_load  = 1'b1;
                        tmr_val   = CLEAR_V;
                        rec_start = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_IDLE: begin
                if (!vcc_ok) begin
                    if (written) begin
                        state_d  = ST_ERASE;
                        soft_d   = 1'b0;
                        tmr_load = 1'b1;
                        tmr_val  = ERASE_V;
                    end else begin
                        state_d = ST_LOWPWR;
                    end
                end else if (sw_store_req) begin
                    state_d  = ST_ERASE;
                    soft_d   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = ERASE_V;
                end else if (sw_recall_req) begin
                    state_d   = ST_CLEAR;
                    soft_d    = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = CLEAR_V;
                    rec_start = 1'b1;
                end else begin
                    wr_accept = sram_wr;
                end
            end
            ST_ERASE: begin
                if (soft_q && !vcc_ok) begin
                    state_d = ST_LOWPWR;
                end else if (tmr_last) begin
                    state_d  = ST_PROG;
                    tmr_load = 1'b1;
                    tmr_val  = PROG_V;
                end
            end
            ST_PROG: begin
                if (soft_q && !vcc_ok) begin
                    state_d = ST_LOWPWR;
                end else if (tmr_last) begin
                    xfer_done = 1'b1;
                    state_d   = vcc_ok ? ST_IDLE : ST_LOWPWR;
                end
            end
            ST_CLEAR: begin
                if (tmr_last) begin
                    state_d  = ST_LOAD;
                    tmr_load = 1'b1;
                    tmr_val  = soft_q ? SW_LOAD_V : PU_LOAD_V;
                end
            end
            ST_LOAD: begin
                if (tmr_last) begin
                    xfer_done = 1'b1;
                    state_d   = vcc_ok ? ST_IDLE : ST_LOWPWR;
                end
            end
            default: state_d = ST_LOWPWR;
        endcase
    end

    // outputs
    always_comb begin
        erase_cmd = (state_q == ST_ERASE);
        prog_cmd  = (state_q == ST_PROG);
        clear_cmd = (state_q == ST_CLEAR);
        xfer_cmd  = (state_q == ST_LOAD);
        busy      = (state_q != ST_IDLE);
        done      = xfer_done;
    end

    // R3: program only follows erase
    a_r3_erase_then_prog: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_cmd) |-> $past(erase_cmd));

    // R4: load only follows clear
    a_r4_clear_then_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_cmd) |-> $past(clear_cmd));

    // R4: array commands never overlap
    a_r4_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({erase_cmd, prog_cmd, clear_cmd, xfer_cmd}));

    // R8: completion is only reported while the port is shut
    a_r8_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R10: a software store stops at once on low supply
    a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
        ((erase_cmd || prog_cmd) && soft_q && !vcc_ok) |=> !(erase_cmd || prog_cmd));

    // R12: done is a single-cycle pulse
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/tb_nv_xfer_ctrl.sv
module tb_nv_xfer_ctrl;
    localparam int ER = 4, PG = 6, CL = 3, RC = 8, RS = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vcc_ok = 1'b0, sw_store_req = 1'b0, sw_recall_req = 1'b0, sram_wr = 1'b0;
    logic erase_cmd, prog_cmd, clear_cmd, xfer_cmd, busy, done;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] sram_m = 8'h00;
    logic [7:0] nv_m = 8'hA5;
    int total = 0, bad = 0;
    int c_er = 0, c_pg = 0, c_cl = 0, c_ld = 0, c_dn = 0, er_at_pg = -1, cl_at_ld = -1;

    always #4 clk = ~clk;

    nv_xfer_ctrl #(.ERASE_CYC(ER), .PROG_CYC(PG), .CLEAR_CYC(CL),
                   .RECALL_CYC(RC), .RESTORE_CYC(RS)) dut (
        .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .sw_store_req(sw_store_req),
        .sw_recall_req(sw_recall_req), .sram_wr(sram_wr), .erase_cmd(erase_cmd),
        .prog_cmd(prog_cmd), .clear_cmd(clear_cmd), .xfer_cmd(xfer_cmd),
        .busy(busy), .done(done));

    // array models
    always @(posedge clk) begin
        if (erase_cmd) nv_m <= 8'h00;
        if (prog_cmd) nv_m <= sram_m;
        if (clear_cmd) sram_m <= 8'h00;
        if (xfer_cmd) sram_m <= nv_m;
        if (sram_wr && !busy) sram_m <= wr_data;
    end

    // phase monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (prog_cmd && c_pg == 0) er_at_pg = c_er;
            if (xfer_cmd && c_ld == 0) cl_at_ld = c_cl;
            if (erase_cmd) c_er++;
            if (prog_cmd) c_pg++;
            if (clear_cmd) c_cl++;
            if (xfer_cmd) c_ld++;
            if (done) c_dn++;
        end
    end

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic clr();
        c_er = 0; c_pg = 0; c_cl = 0; c_ld = 0; c_dn = 0; er_at_pg = -1; cl_at_ld = -1;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200; i++) begin
            tick(1);
            if (!busy) break;
        end
    endtask

    task automatic do_write(input logic [7:0] v);
        sram_wr = 1'b1; wr_data = v;
        tick(1);
        sram_wr = 1'b0;
        tick(1);
    endtask

    task automatic pulse(input logic st, input logic rc);
        sw_store_req = st; sw_recall_req = rc;
        tick(1);
        sw_store_req = 1'b0; sw_recall_req = 1'b0;
    endtask

    task automatic t_reset();
        tick(3);
        chk("R1 busy in reset", busy, 1);
        chk("R1 cmds in reset", {erase_cmd, prog_cmd, clear_cmd, xfer_cmd, done}, 0);
        rst_n = 1'b1;
        tick(4);
        chk("R1 busy low power", busy, 1);
        chk("R1 no recall before supply", c_cl, 0);
    endtask

    task automatic t_powerup();
        clr();
        vcc_ok = 1'b1;
        tick(1);
        sram_wr = 1'b1; wr_data = 8'hFF; sw_store_req = 1'b1;
        tick(4);
        sram_wr = 1'b0; sw_store_req = 1'b0;
        wait_idle();
        chk("R2 clear cycles", c_cl, CL);
        chk("R2 load cycles", c_ld, RS - CL);
        chk("R2 clear before load", cl_at_ld, CL);
        chk("R12 done count", c_dn, 1);
        chk("R2 sram restored", sram_m, 8'hA5);
        tick(5);
        chk("R8 request while busy ignored", c_er, 0);
    endtask

    task automatic t_nowrite_drop();
        clr();
        vcc_ok = 1'b0;
        tick(20);
        chk("R5 no store when clean", c_er, 0);
        chk("R8 write during recall ignored", c_pg, 0);
        chk("R5 low power busy", busy, 1);
        vcc_ok = 1'b1;
        tick(5);
        chk("R2 idle after rise", busy, 0);
        chk("R2 no recall without pending", c_cl, 0);
    endtask

    task automatic t_auto_store();
        do_write(8'h3C);
        clr();
        vcc_ok = 1'b0;
        tick(20);
        chk("R5 erase cycles", c_er, ER);
        chk("R3 prog cycles", c_pg, PG);
        chk("R3 erase before prog", er_at_pg, ER);
        chk("R12 done count", c_dn, 1);
        chk("R5 shadow stored", nv_m, 8'h3C);
        chk("R5 busy after store", busy, 1);
        clr();
        pulse(1'b1, 1'b0);
        tick(10);
        chk("R9 store ignored low", c_er, 0);
        pulse(1'b0, 1'b1);
        tick(10);
        chk("R9 recall held", c_cl, 0);
        vcc_ok = 1'b1;
        wait_idle();
        chk("R9 held recall clear", c_cl, CL);
        chk("R9 held recall load", c_ld, RS - CL);
        chk("R9 sram", sram_m, 8'h3C);
    endtask

    task automatic t_sw_store();
        do_write(8'h77);
        clr();
        pulse(1'b1, 1'b0);
        wait_idle();
        chk("R3 erase cycles", c_er, ER);
        chk("R3 prog cycles", c_pg, PG);
        chk("R12 done", c_dn, 1);
        chk("R3 shadow", nv_m, 8'h77);
        clr();
        pulse(1'b1, 1'b0);
        wait_idle();
        chk("R7 clean store runs", c_er, ER);
        do_write(8'h55);
        clr();
        pulse(1'b1, 1'b0);
        wait_idle();
        clr();
        vcc_ok = 1'b0;
        tick(20);
        chk("R6 flag cleared by store", c_er, 0);
        vcc_ok = 1'b1;
        tick(5);
    endtask

    task automatic t_sw_recall();
        do_write(8'h11);
        clr();
        pulse(1'b0, 1'b1);
        wait_idle();
        chk("R4 clear cycles", c_cl, CL);
        chk("R4 load cycles", c_ld, RC - CL);
        chk("R4 no erase", c_er + c_pg, 0);
        chk("R4 sram", sram_m, 8'h55);
        chk("R4 shadow unchanged", nv_m, 8'h55);
        chk("R12 done", c_dn, 1);
        clr();
        vcc_ok = 1'b0;
        tick(20);
        chk("R6 flag cleared by recall", c_er, 0);
        vcc_ok = 1'b1;
        tick(5);
    endtask

    task automatic t_both();
        do_write(8'h22);
        clr();
        pulse(1'b1, 1'b1);
        wait_idle();
        tick(5);
        chk("R11 store runs", c_er, ER);
        chk("R11 recall dropped", c_cl, 0);
        chk("R11 shadow", nv_m, 8'h22);
    endtask

    task automatic t_abort();
        clr();
        pulse(1'b1, 1'b0);
        vcc_ok = 1'b0;
        tick(20);
        chk("R10 erase cut short", (c_er < ER) ? 1 : 0, 1);
        chk("R10 no program", c_pg, 0);
        chk("R10 no done", c_dn, 0);
        chk("R10 low power", busy, 1);
        vcc_ok = 1'b1;
        tick(5);
        chk("R10 idle after rise", busy, 0);
        chk("R10 no recall", c_cl, 0);
    endtask

    initial begin
        t_reset();
        t_powerup();
        t_nowrite_drop();
        t_auto_store();
        t_sw_store();
        t_sw_recall();
        t_both();
        t_abort();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule